// File: doc/BRIEF.md
# Two-Channel Probabilistic Looping Gate and CV Sequencer

The block is a clocked random-loop sequencer with two channels. Each channel keeps a 16-bit state register. Only its low n bits form the loop, where n is 2, 4, 8 or 16. On every rising edge of an external step clock, a channel does three things. It drives its gate from the top bit of the loop and, when that gate is high, refreshes a 12-bit control-voltage word scaled from the loop contents. It then rotates the loop by one place. The bit that re-enters at the bottom is either the output bit unchanged or its complement. A lock threshold decides which, by comparing itself against an internal pseudo-random draw.

A shared 10-bit lock value sets the threshold. Each channel adds its own 10-bit modulation input, scaled by 1.7, and removes a fixed centre offset. A low threshold keeps the loop frozen. A high threshold makes it flip on every step. A direction input can reverse the sense of the threshold for channel B alone. The step clock may be asynchronous to the system clock, because it is synchronized inside the block.

Top module: `loop_seq_2ch`

## Requirements
- R1: While reset is asserted, and after it is released, both gates are 0 and both CV words are 0. Channel A starts its state at 0xAAAA and channel B at 0x5555.
- R2: `len_sel` selects the loop length n as follows: 0 gives 2, 1 gives 4, 2 gives 8 and 3 gives 16. On a step, each gate takes bit n-1 of its channel's state.
- R3: On a step, the state becomes ((state << 1) masked to the low n bits), and the feedback bit is placed in bit 0.
- R4: The feedback bit equals the output bit when the effective threshold is strictly less than a random draw in 6..1023. Otherwise it is the complement. A threshold of 5 or less therefore always keeps the bit, and a threshold of 1023 or more always inverts it.
- R5: A channel's threshold is lock + (cv*17)/10 - 525, using integer division, clamped to 0..1023.
- R6: With `dir_fwd`=1, channel B uses its threshold as it is. With `dir_fwd`=0, channel B uses 1024 minus its threshold. Channel A is never affected by `dir_fwd`.
- R7: On a step, the CV word is the low n bits of the state. That value is shifted left by 12-n when n is 12 or less, and shifted right by 4 when n is 16.
- R8: A channel's CV word changes only on a step where that channel's gate becomes 1. On every other step, and between steps, it holds its value.
- R9: A falling edge of the step clock drives both gates to 0. Gates change only on step-clock edges.
- R10: `len_sel` and `dir_fwd` are captured on every cycle that is not a step, and are held during a step. A change made three or more system clocks before a rising step-clock edge applies to that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_clk | input | 1 | Asynchronous step clock |
| lock_val | input | 10 | Shared lock amount |
| cv_mod_a | input | 10 | Threshold modulation, channel A |
| cv_mod_b | input | 10 | Threshold modulation, channel B |
| len_sel | input | 2 | Loop length code |
| dir_fwd | input | 1 | 1 = normal lock sense for channel B, 0 = reversed |
| gate_a | output | 1 | Gate, channel A |
| gate_b | output | 1 | Gate, channel B |
| cv_out_a | output | 12 | CV word, channel A |
| cv_out_b | output | 12 | CV word, channel B |

## Verification
The bench builds the block with its default parameters: gain 17/10, centre 525, draw floor 6, and start patterns 0xAAAA and 0x5555. With these values, a threshold of 5 or less and a threshold of 1023 or more both give a result that does not depend on the random draw. The bench therefore drives lock and modulation values that land on those extremes, and on the exact floor of 5. This puts keep, invert, reversed sense, every loop length and CV hold on silent steps within reach of an exact per-step prediction.

// File: rtl/loop_seq_2ch.sv
module loop_seq_2ch #(
  parameter int          GAIN_NUM  = 17,
  parameter int          GAIN_DEN  = 10,
  parameter int          NEUTRAL   = 525,
  parameter int          RND_MIN   = 6,
  parameter logic [15:0] INIT_A    = 16'hAAAA,
  parameter logic [15:0] INIT_B    = 16'h5555,
  parameter logic [31:0] PRNG_SEED = 32'h1ACE_B00C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step_clk,
  input  logic [9:0]  lock_val,
  input  logic [9:0]  cv_mod_a,
  input  logic [9:0]  cv_mod_b,
  input  logic [1:0]  len_sel,
  input  logic        dir_fwd,
  output logic        gate_a,
  output logic        gate_b,
  output logic [11:0] cv_out_a,
  output logic [11:0] cv_out_b
);
  localparam logic [31:0] PRNG_TAPS = 32'hA300_0000;
  localparam logic [9:0]  RND_RST   = 10'd512;

  logic        s1, s2, s3;
  logic        rise, fall;
  logic [1:0]  len_q;
  logic        dir_q;
  logic [15:0] reg_a, reg_b;
  logic [31:0] prng;
  logic [9:0]  rnd_a, rnd_b;
  logic [4:0]  nbits;
  logic [15:0] mask;
  logic        out_a, out_b;
  logic [10:0] thr_a, thr_b, eff_b;
  logic        new_a, new_b;

  function automatic logic [10:0] lock_thr(input logic [9:0] lk, input logic [9:0] cv);
    int s;
    s = int'(lk) + (int'(cv) * GAIN_NUM) / GAIN_DEN - NEUTRAL;
    if (s < 0) s = 0;
    if (s > 1023) s = 1023;
    return 11'(s);
  endfunction

  function automatic logic [11:0] cv_scale(input logic [15:0] w, input logic [1:0] l);
    case (l)
      2'd0:    return {w[1:0], 10'd0};
      2'd1:    return {w[3:0], 8'd0};
      2'd2:    return {w[7:0], 4'd0};
      default: return w[15:4];
    endcase
  endfunction

  assign rise  = s2 & ~s3;
  assign fall  = ~s2 & s3;
  assign nbits = 5'd2 << len_q;
  assign mask  = 16'((17'h1 << nbits) - 17'h1);
  assign out_a = reg_a[4'(nbits - 5'd1)];
  assign out_b = reg_b[4'(nbits - 5'd1)];
  assign thr_a = lock_thr(lock_val, cv_mod_a);
  assign thr_b = lock_thr(lock_val, cv_mod_b);
  assign eff_b = dir_q ? thr_b : 11'd1024 - thr_b;
  assign new_a = (thr_a < {1'b0, rnd_a}) ? out_a : ~out_a;
  assign new_b = (eff_b < {1'b0, rnd_b}) ? out_b : ~out_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {s1, s2, s3} <= 3'b000;
      prng  <= PRNG_SEED;
      rnd_a <= RND_RST;
      rnd_b <= RND_RST;
    end else begin
      {s1, s2, s3} <= {step_clk, s1, s2};
      prng <= {1'b0, prng[31:1]} ^ (prng[0] ? PRNG_TAPS : 32'h0);
      if (prng[9:0] >= 10'(RND_MIN))   rnd_a <= prng[9:0];
      if (prng[25:16] >= 10'(RND_MIN)) rnd_b <= prng[25:16];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q    <= 2'd3;
      dir_q    <= 1'b1;
      reg_a    <= INIT_A;
      reg_b    <= INIT_B;
      gate_a   <= 1'b0;
      gate_b   <= 1'b0;
      cv_out_a <= 12'd0;
      cv_out_b <= 12'd0;
    end else begin
      if (rise) begin
        gate_a <= out_a;
        gate_b <= out_b;
        if (out_a) cv_out_a <= cv_scale(reg_a & mask, len_q);
        if (out_b) cv_out_b <= cv_scale(reg_b & mask, len_q);
        reg_a <= ((reg_a << 1) & mask) | {15'd0, new_a};
        reg_b <= ((reg_b << 1) & mask) | {15'd0, new_b};
      end else begin
        len_q <= len_sel;
        dir_q <= dir_fwd;
        if (fall) begin
          gate_a <= 1'b0;
          gate_b <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/loop_seq_2ch_chk.sv
module loop_seq_2ch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rise,
  input logic        fall,
  input logic        gate_a,
  input logic        gate_b,
  input logic [11:0] cv_out_a,
  input logic [11:0] cv_out_b,
  input logic [9:0]  rnd_a,
  input logic [9:0]  rnd_b,
  input logic [1:0]  len_q,
  input logic        dir_q,
  input logic [15:0] reg_a,
  input logic [15:0] reg_b,
  input logic [4:0]  nbits
);
  AST_FALL_CLEARS_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> (!gate_a && !gate_b)); // R9

  AST_GATE_RISES_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_a) || $rose(gate_b)) |-> $past(rise)); // R9

  AST_CV_A_ONLY_WITH_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_out_a != $past(cv_out_a)) |-> (gate_a && $past(rise))); // R8

  AST_CV_B_ONLY_WITH_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_out_b != $past(cv_out_b)) |-> (gate_b && $past(rise))); // R8

  AST_DRAW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_a >= 10'd6) && (rnd_b >= 10'd6)); // R4

  AST_WINDOW_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (((reg_a >> $past(nbits)) == 16'd0) && ((reg_b >> $past(nbits)) == 16'd0))); // R3

  AST_CONFIG_HELD_IN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> ($stable(len_q) && $stable(dir_q))); // R10
endmodule

bind loop_seq_2ch loop_seq_2ch_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
  .gate_a(gate_a), .gate_b(gate_b), .cv_out_a(cv_out_a), .cv_out_b(cv_out_b),
  .rnd_a(rnd_a), .rnd_b(rnd_b), .len_q(len_q), .dir_q(dir_q),
  .reg_a(reg_a), .reg_b(reg_b), .nbits(nbits)
);

// File: tb/loop_seq_2ch_tb_top.sv
module loop_seq_2ch_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, step_clk = 1'b0, dir_fwd = 1'b1;
  logic [9:0] lock_val = '0, cv_mod_a = '0, cv_mod_b = '0;
  logic [1:0] len_sel = 2'd3;
  logic gate_a, gate_b;
  logic [11:0] cv_out_a, cv_out_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_seq_2ch dut_i (
    .clk(clk), .rst_n(rst_n), .step_clk(step_clk), .lock_val(lock_val),
    .cv_mod_a(cv_mod_a), .cv_mod_b(cv_mod_b), .len_sel(len_sel), .dir_fwd(dir_fwd),
    .gate_a(gate_a), .gate_b(gate_b), .cv_out_a(cv_out_a), .cv_out_b(cv_out_b)
  );

  typedef struct {
    logic        ga, gb;
    logic [11:0] ca, cb;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  int ma = 16'hAAAA, mb = 16'h5555;
  logic [11:0] hold_a = '0, hold_b = '0;

  function automatic int thr(int lk, int cv);
    int s = lk + (cv * 17) / 10 - 525;
    if (s < 0) s = 0;
    if (s > 1023) s = 1023;
    return s;
  endfunction

  function automatic int decide(int eff);
    if (eff < 6) return 0;
    if (eff >= 1023) return 1;
    return 2;
  endfunction

  function automatic logic [11:0] scale(int w, int n);
    if (n <= 12) return 12'((w << (12 - n)) & 12'hFFF);
    return 12'(w >> (n - 12));
  endfunction

  initial begin : monitor
    exp_t it;
    forever begin
      wait (q.size() != 0);
      it = q.pop_front();
      checks++;
      if (gate_a !== it.ga || gate_b !== it.gb || cv_out_a !== it.ca || cv_out_b !== it.cb) begin
        fails++;
        $display("FAIL %s: got gates %b%b cv %h/%h, expected gates %b%b cv %h/%h",
                 it.tag, gate_a, gate_b, cv_out_a, cv_out_b, it.ga, it.gb, it.ca, it.cb);
      end
    end
  end

  task automatic push(input exp_t e);
    q.push_back(e);
    wait (q.size() == 0);
  endtask

  task automatic step(input string tag);
    int n = 2 << len_sel;
    int msk = (1 << n) - 1;
    int ta = thr(lock_val, cv_mod_a);
    int tb = thr(lock_val, cv_mod_b);
    int da = decide(ta);
    int db = decide(dir_fwd ? tb : 1024 - tb);
    int oa = (ma >> (n - 1)) & 1;
    int ob = (mb >> (n - 1)) & 1;
    exp_t e;
    if (da == 2 || db == 2) begin
      fails++;
      $display("FAIL %s: stimulus gives undetermined decision, got %0d/%0d expected 0 or 1", tag, da, db);
    end
    if (oa == 1) hold_a = scale(ma & msk, n);
    if (ob == 1) hold_b = scale(mb & msk, n);
    ma = ((ma << 1) & msk) | (da == 1 ? 1 - oa : oa);
    mb = ((mb << 1) & msk) | (db == 1 ? 1 - ob : ob);
    step_clk = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    e = '{ga: oa[0], gb: ob[0], ca: hold_a, cb: hold_b, tag: tag};
    push(e);
    step_clk = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    e = '{ga: 1'b0, gb: 1'b0, ca: hold_a, cb: hold_b, tag: "R9"};
    push(e);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : driver
    exp_t e;
    repeat (3) @(posedge clk);
    @(negedge clk);
    e = '{ga: 1'b0, gb: 1'b0, ca: 12'd0, cb: 12'd0, tag: "R1"};
    push(e);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    e = '{ga: 1'b0, gb: 1'b0, ca: 12'd0, cb: 12'd0, tag: "R1"};
    push(e);

    // keep both: threshold 0
    repeat (3) step("R3");
    // R5: lock 0 + 1023*1.7 - 525 clamps to 1023 on A (invert); B stays at 0 (keep)
    cv_mod_a = 10'd1023;
    repeat (3) step("R5");
    // R6: reversed sense
    cv_mod_a = 10'd0; dir_fwd = 1'b0;
    repeat (3) @(negedge clk);
    repeat (3) step("R6");
    lock_val = 10'd1023; cv_mod_a = 10'd309; cv_mod_b = 10'd309;
    repeat (2) step("R6");
    // R4: threshold exactly 5 always keeps
    dir_fwd = 1'b1; lock_val = 10'd5;
    repeat (3) @(negedge clk);
    repeat (3) step("R4");
    // invert on both, walk lengths
    lock_val = 10'd1023;
    len_sel = 2'd0;
    repeat (3) @(negedge clk);
    repeat (4) step("R2");
    len_sel = 2'd1;
    repeat (3) @(negedge clk);
    repeat (5) step("R7");
    len_sel = 2'd2;
    repeat (3) @(negedge clk);
    repeat (9) step("R8");
    lock_val = 10'd0; cv_mod_a = 10'd0; cv_mod_b = 10'd0;
    repeat (3) step("R8");
    len_sel = 2'd3; lock_val = 10'd1023; cv_mod_a = 10'd309; cv_mod_b = 10'd309;
    repeat (3) @(negedge clk);
    repeat (4) step("R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule